// File: doc/BRIEF.md
# Atomic Read-Modify-Write Engine

This block runs indivisible 32-bit read-modify-write operations against a single-port word memory. A requester presents an operation code, a byte address and a source operand. The engine reads the addressed word, combines it with the operand and writes the combined value back to the same word. It returns the value it read, sign-extended to the register width. No second request is accepted until the first one completes, so no other access can reach the memory between the read and the write.

The engine also provides a load-reserved / store-conditional pair that is tracked by one reservation register. It also accepts a plain store, which can break a reservation. A word address that is not 4-byte aligned is rejected with an error flag and never reaches the memory. The memory side uses a level request. The request, write-enable, address and write data are held until the memory answers with a one-cycle ready. Read data is taken in the cycle that ready is high.

Top module: `amo_engine`

## Requirements
- R1: An atomic operation (codes 0 to 8) reads the word at the request address. It returns the old word and then writes the combined word back to that same address. The memory address stays unchanged from the read through the write.
- R2: The operation code selects the combine function as follows: 0 swap (operand), 1 add, 2 bitwise and, 3 bitwise or, 4 bitwise xor, 5 signed min, 6 signed max, 7 unsigned min, 8 unsigned max. Codes 12 to 15 behave as swap.
- R3: The signed min/max codes compare the two words as two's-complement values. The unsigned codes compare them as magnitudes.
- R4: The 32-bit value returned by an atomic operation or a load-reserved is sign-extended to XLEN bits (default 64).
- R5: A request whose address bits [1:0] are not zero completes with resp_misaligned=1 and resp_data=0. It issues no memory request and leaves the reservation unchanged.
- R6: Load-reserved (code 9) reads the word, returns it sign-extended and records a reservation on that word address.
- R7: Store-conditional (code 10) to the reserved word writes the operand to memory and returns 0.
- R8: A store-conditional with no matching reservation writes nothing and returns 1. Every aligned store-conditional clears the reservation, whether it succeeds or fails.
- R9: A plain store (code 11) writes the operand and returns 0. A completed write by a store or atomic operation to the reserved word clears the reservation. A write to any other word leaves the reservation in place.
- R10: req_ready is high only while the engine is idle. resp_valid is a single-cycle pulse, and req_ready returns high in the following cycle.
- R11: After reset, req_ready=1, resp_valid=0, mem_req=0, and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_op | input | 4 | Operation code |
| req_addr | input | AW | Byte address |
| req_operand | input | DW | Source operand |
| req_ready | output | 1 | Engine idle and able to take a request |
| resp_valid | output | 1 | Result valid for one cycle |
| resp_data | output | XLEN | Old word sign-extended, or store-conditional code |
| resp_misaligned | output | 1 | Request rejected for misalignment |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the pending access |

## Verification
The reservation check of a store-conditional and the clearing of that reservation happen in the same acceptance cycle. The write completion of a store or atomic operation can also clear the reservation that an earlier load-reserved set. The bench places a store-conditional directly after a load-reserved and judges success by the returned 0 and the memory word. It then issues a second store-conditional at once and expects the value 1 with memory unchanged. Stores and atomic operations to the reserved word and to a neighbouring word are placed between load-reserved and store-conditional. A misaligned store-conditional is placed there as well. The outcome of the final store-conditional shows whether each of these cleared the reservation.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [3:0] {
    OP_SWAP  = 4'd0,
    OP_ADD   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_MIN   = 4'd5,
    OP_MAX   = 4'd6,
    OP_MINU  = 4'd7,
    OP_MAXU  = 4'd8,
    OP_LR    = 4'd9,
    OP_SC    = 4'd10,
    OP_STORE = 4'd11
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_READ,
    ST_WRITE,
    ST_WAIT_WRITE,
    ST_DONE
  } amo_state_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DW = 32
) (
  input  amo_op_e         op,
  input  logic [DW-1:0]   mem_val,
  input  logic [DW-1:0]   src_val,
  output logic [DW-1:0]   result
);
  logic lt_signed;
  logic lt_unsigned;

  assign lt_signed   = $signed(mem_val) < $signed(src_val);
  assign lt_unsigned = mem_val < src_val;

  always_comb begin
    case (op)
      OP_ADD:  result = mem_val + src_val;
      OP_AND:  result = mem_val & src_val;
      OP_OR:   result = mem_val | src_val;
      OP_XOR:  result = mem_val ^ src_val;
      OP_MIN:  result = lt_signed   ? mem_val : src_val;
      OP_MAX:  result = lt_signed   ? src_val : mem_val;
      OP_MINU: result = lt_unsigned ? mem_val : src_val;
      OP_MAXU: result = lt_unsigned ? src_val : mem_val;
      default: result = src_val;
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int AW  = 32,
  parameter int LSB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic          clr_all,
  input  logic          wr_done,
  input  logic [AW-1:0] op_addr,
  input  logic [AW-1:0] query_addr,
  output logic          hit
);
  localparam int TW = AW - LSB;

  logic          valid_q;
  logic [TW-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (clr_all) begin
      valid_q <= 1'b0;
    end else if (wr_done && valid_q && (op_addr[AW-1:LSB] == tag_q)) begin
      valid_q <= 1'b0;
    end else if (set_en) begin
      valid_q <= 1'b1;
      tag_q   <= op_addr[AW-1:LSB];
    end
  end

  assign hit = valid_q && (query_addr[AW-1:LSB] == tag_q);

  AST_SC_DROPS_RESV: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> !valid_q); // R8
  AST_LR_SETS_RESV: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr_all) |=> valid_q); // R6
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int XLEN = 64,
  parameter int OPW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [OPW-1:0]  req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_operand,
  output logic            req_ready,
  output logic            resp_valid,
  output logic [XLEN-1:0] resp_data,
  output logic            resp_misaligned,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output amo_op_e         alu_op,
  output logic [DW-1:0]   alu_src,
  input  logic [DW-1:0]   alu_res,
  input  logic            resv_hit,
  output logic            resv_set,
  output logic            resv_clr_all,
  output logic            resv_wr_done,
  output logic [AW-1:0]   resv_addr
);
  localparam int OFFW = $clog2(DW / 8);

  amo_state_e      state_q;
  amo_op_e         op_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   opnd_q;
  logic [DW-1:0]   wdata_q;
  logic [XLEN-1:0] rdata_q;
  logic            err_q;

  amo_op_e         in_op;
  logic            in_misal;
  logic            accept;
  logic            rd_phase;
  logic            wr_phase;

  assign in_op    = amo_op_e'(req_op);
  assign in_misal = |req_addr[OFFW-1:0];
  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign rd_phase = (state_q == ST_READ) || (state_q == ST_WAIT_READ);
  assign wr_phase = (state_q == ST_WRITE) || (state_q == ST_WAIT_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_SWAP;
      addr_q  <= '0;
      opnd_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            op_q   <= in_op;
            addr_q <= req_addr;
            opnd_q <= req_operand;
            err_q  <= in_misal;
            if (in_misal) begin
              rdata_q <= '0;
              state_q <= ST_DONE;
            end else if (in_op == OP_SC) begin
              if (resv_hit) begin
                wdata_q <= req_operand;
                rdata_q <= '0;
                state_q <= ST_WRITE;
              end else begin
                rdata_q <= XLEN'(1);
                state_q <= ST_DONE;
              end
            end else if (in_op == OP_STORE) begin
              wdata_q <= req_operand;
              rdata_q <= '0;
              state_q <= ST_WRITE;
            end else begin
              state_q <= ST_READ;
            end
          end
        end
        ST_READ, ST_WAIT_READ: begin
          if (mem_ready) begin
            rdata_q <= XLEN'(signed'(mem_rdata));
            wdata_q <= alu_res;
            state_q <= (op_q == OP_LR) ? ST_DONE : ST_WRITE;
          end else begin
            state_q <= ST_WAIT_READ;
          end
        end
        ST_WRITE, ST_WAIT_WRITE: begin
          state_q <= mem_ready ? ST_DONE : ST_WAIT_WRITE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready       = (state_q == ST_IDLE);
  assign resp_valid      = (state_q == ST_DONE);
  assign resp_data       = rdata_q;
  assign resp_misaligned = err_q;
  assign mem_req         = rd_phase || wr_phase;
  assign mem_we          = wr_phase;
  assign mem_addr        = addr_q;
  assign mem_wdata       = wdata_q;

  assign alu_op  = op_q;
  assign alu_src = opnd_q;

  assign resv_set     = rd_phase && mem_ready && (op_q == OP_LR);
  assign resv_clr_all = accept && !in_misal && (in_op == OP_SC);
  assign resv_wr_done = wr_phase && mem_ready;
  assign resv_addr    = addr_q;

  AST_MISALIGN_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (accept && in_misal) |=> (resp_valid && !mem_req && resp_misaligned)); // R5
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> (!resp_valid && req_ready)); // R10
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr)); // R1
  AST_SC_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_misal && (in_op == OP_SC) && !resv_hit) |=> (!mem_req && resp_data == XLEN'(1))); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready); // R10
endmodule

// File: rtl/amo_engine.sv
module amo_engine
  import amo_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int XLEN = 64,
  parameter int OPW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [OPW-1:0]  req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_operand,
  output logic            req_ready,
  output logic            resp_valid,
  output logic [XLEN-1:0] resp_data,
  output logic            resp_misaligned,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready
);
  localparam int OFFW = $clog2(DW / 8);

  amo_op_e       alu_op;
  logic [DW-1:0] alu_src;
  logic [DW-1:0] alu_res;
  logic          resv_hit;
  logic          resv_set;
  logic          resv_clr_all;
  logic          resv_wr_done;
  logic [AW-1:0] resv_addr;

  amo_ctrl #(.AW(AW), .DW(DW), .XLEN(XLEN), .OPW(OPW)) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_op          (req_op),
    .req_addr        (req_addr),
    .req_operand     (req_operand),
    .req_ready       (req_ready),
    .resp_valid      (resp_valid),
    .resp_data       (resp_data),
    .resp_misaligned (resp_misaligned),
    .mem_req         (mem_req),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr),
    .mem_wdata       (mem_wdata),
    .mem_rdata       (mem_rdata),
    .mem_ready       (mem_ready),
    .alu_op          (alu_op),
    .alu_src         (alu_src),
    .alu_res         (alu_res),
    .resv_hit        (resv_hit),
    .resv_set        (resv_set),
    .resv_clr_all    (resv_clr_all),
    .resv_wr_done    (resv_wr_done),
    .resv_addr       (resv_addr)
  );

  amo_alu #(.DW(DW)) u_alu (
    .op      (alu_op),
    .mem_val (mem_rdata),
    .src_val (alu_src),
    .result  (alu_res)
  );

  amo_resv #(.AW(AW), .LSB(OFFW)) u_resv (
    .clk        (clk),
    .rst        (rst),
    .set_en     (resv_set),
    .clr_all    (resv_clr_all),
    .wr_done    (resv_wr_done),
    .op_addr    (resv_addr),
    .query_addr (req_addr),
    .hit        (resv_hit)
  );
endmodule

// File: tb/sim_amo_engine.sv
module sim_amo_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = 4'd0;
  logic [31:0] req_addr = 32'd0;
  logic [31:0] req_operand = 32'd0;
  logic        req_ready;
  logic        resp_valid;
  logic [63:0] resp_data;
  logic        resp_misaligned;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  int nmem   = 0;
  int stall  = 0;
  int wcnt   = 0;
  logic [31:0] mem [16];

  always #5 clk = ~clk;

  amo_engine u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_operand(req_operand), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_misaligned(resp_misaligned), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  assign mem_rdata = mem[mem_addr[5:2]];

  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0;
      wcnt      <= 0;
    end else begin
      if (mem_req) nmem <= nmem + 1;
      if (mem_req && mem_we && mem_ready) mem[mem_addr[5:2]] <= mem_wdata;
      if (mem_req && !mem_ready) begin
        if (wcnt >= stall) begin
          mem_ready <= 1'b1;
          wcnt      <= 0;
        end else begin
          wcnt <= wcnt + 1;
        end
      end else begin
        mem_ready <= 1'b0;
      end
    end
  end

  // {op, initial word, operand, expected written word}
  localparam int NV = 11;
  localparam logic [99:0] VEC [NV] = '{
    {4'd0, 32'h12345678, 32'hCAFEF00D, 32'hCAFEF00D},
    {4'd1, 32'hFFFFFFFF, 32'h00000002, 32'h00000001},
    {4'd2, 32'hF0F0F0F0, 32'h3C3C3C3C, 32'h30303030},
    {4'd3, 32'hF0F0F0F0, 32'h0F000001, 32'hFFF0F0F1},
    {4'd4, 32'hAAAA5555, 32'hFFFF0000, 32'h55555555},
    {4'd5, 32'h80000000, 32'h00000001, 32'h80000000},
    {4'd6, 32'h80000000, 32'h00000001, 32'h00000001},
    {4'd7, 32'h80000000, 32'h00000001, 32'h00000001},
    {4'd8, 32'h80000000, 32'h00000001, 32'h80000000},
    {4'd6, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF},
    {4'd8, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [31:0] addr,
                       input logic [31:0] opnd, output logic [63:0] rd, output logic err);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_operand = opnd; nmem = 0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy ready low", {63'd0, req_ready}, 64'd0);
    while (!resp_valid) @(negedge clk);
    rd  = resp_data;
    err = resp_misaligned;
    @(negedge clk);
    chk("R10 single pulse", {63'd0, resp_valid}, 64'd0);
  endtask

  logic [63:0] r;
  logic        e;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R11 ready", {63'd0, req_ready}, 64'd1);
    chk("R11 resp", {63'd0, resp_valid}, 64'd0);
    chk("R11 memreq", {63'd0, mem_req}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    // R11: no reservation after reset -> store-conditional fails
    mem[12] = 32'h0BAD0BAD;
    do_op(4'd10, 32'h30, 32'h11111111, r, e);
    chk("R11 sc after reset", r, 64'd1);
    chk("R11 no write", {32'd0, mem[12]}, {32'd0, 32'h0BAD0BAD});

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  vop;
      logic [31:0] vinit, vsrc, vnew;
      {vop, vinit, vsrc, vnew} = VEC[i];
      stall = i % 3;
      mem[i] = vinit;
      do_op(vop, i * 4, vsrc, r, e);
      chk("R1/R4 old value returned", r, {{32{vinit[31]}}, vinit});
      chk("R1 no error", {63'd0, e}, 64'd0);
      if (vop >= 4'd5) chk("R3 min/max written", {32'd0, mem[i]}, {32'd0, vnew});
      else             chk("R2 combine written", {32'd0, mem[i]}, {32'd0, vnew});
    end
    stall = 0;

    // R2: unused code behaves as swap
    mem[11] = 32'h00000005;
    do_op(4'd14, 32'h2C, 32'h0000ABCD, r, e);
    chk("R2 unused code swap", {32'd0, mem[11]}, 64'h0000ABCD);

    // R5 misaligned
    mem[2] = 32'h01020304;
    do_op(4'd1, 32'h0A, 32'h1, r, e);
    chk("R5 error flag", {63'd0, e}, 64'd1);
    chk("R5 data zero", r, 64'd0);
    chk("R5 no mem access", nmem, 0);
    chk("R5 mem unchanged", {32'd0, mem[2]}, 64'h01020304);

    // R6/R7: LR then SC succeeds; second SC fails (R8)
    mem[12] = 32'h8000ABCD;
    do_op(4'd9, 32'h30, 32'h0, r, e);
    chk("R6 lr value", r, 64'hFFFFFFFF8000ABCD);
    do_op(4'd10, 32'h30, 32'h22222222, r, e);
    chk("R7 sc success code", r, 64'd0);
    chk("R7 sc wrote", {32'd0, mem[12]}, 64'h22222222);
    do_op(4'd10, 32'h30, 32'h33333333, r, e);
    chk("R8 sc repeat fails", r, 64'd1);
    chk("R8 sc no write", {32'd0, mem[12]}, 64'h22222222);

    // R8: SC to another word fails and still drops the reservation
    do_op(4'd9, 32'h30, 32'h0, r, e);
    do_op(4'd10, 32'h34, 32'h44444444, r, e);
    chk("R8 sc other word fails", r, 64'd1);
    do_op(4'd10, 32'h30, 32'h55555555, r, e);
    chk("R8 failed sc cleared resv", r, 64'd1);

    // R9: store to other word keeps reservation
    do_op(4'd9, 32'h30, 32'h0, r, e);
    do_op(4'd11, 32'h34, 32'h66666666, r, e);
    chk("R9 store code", r, 64'd0);
    chk("R9 store wrote", {32'd0, mem[13]}, 64'h66666666);
    do_op(4'd10, 32'h30, 32'h77777777, r, e);
    chk("R9 resv kept", r, 64'd0);

    // R9: store to reserved word drops it
    do_op(4'd9, 32'h30, 32'h0, r, e);
    do_op(4'd11, 32'h30, 32'h88888888, r, e);
    do_op(4'd10, 32'h30, 32'h99999999, r, e);
    chk("R9 store clears resv", r, 64'd1);
    chk("R9 mem after store", {32'd0, mem[12]}, 64'h88888888);

    // R9: atomic add to reserved word drops it
    do_op(4'd9, 32'h30, 32'h0, r, e);
    do_op(4'd1, 32'h30, 32'h1, r, e);
    do_op(4'd10, 32'h30, 32'h12121212, r, e);
    chk("R9 amo clears resv", r, 64'd1);
    chk("R9 mem after amo", {32'd0, mem[12]}, 64'h88888889);

    // R5: misaligned SC leaves reservation intact
    do_op(4'd9, 32'h30, 32'h0, r, e);
    do_op(4'd10, 32'h32, 32'hDEADBEEF, r, e);
    chk("R5 misaligned sc flagged", {63'd0, e}, 64'd1);
    do_op(4'd10, 32'h30, 32'h13131313, r, e);
    chk("R5 resv survives misaligned", r, 64'd0);
    chk("R7 sc wrote after", {32'd0, mem[12]}, 64'h13131313);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule